// File: doc/BRIEF.md
# Low-Power Halt Clock Gate Controller

This block decides when the core's internal clock is switched off on a halt and when it comes back. It runs on the free-running clock and produces a gated copy for the core. A halt can begin in two ways, each with its own enable bit. The first is a one-cycle halt strobe from the core. The second is an active-low suspend pin, which can change at any time and is first brought through a synchronizer.

Once the gate has closed, the block drives an active-low acknowledge low. It stays in the halted state until a wake event that fits the way the halt began:

- A halt entered through the pin ends only when the pin is released, or on the asynchronous reset.
- A halt entered through the strobe ends on a soft reset, a management interrupt, an NMI, or an INTR that the interrupt flag permits.

While the core is in management mode, a halt strobe is taken only if some wake source is enabled. Each wake records a cause code. The gate itself is a latch that is open only in the low phase of the clock followed by an AND, so the gated clock never produces a short pulse.

Top module: `lph_clk_ctrl`

## Requirements
- R1: While rst_ni is low, and from the first edge after it is released, gclk_o follows clk_i, susp_ack_no is 1 and wake_src_o is 0. Asserting rst_ni while halted brings the clock back at once.
- R2: A halt strobe sampled at edge k while sw_halt_en_i is 1 lets gclk_o pulse at edge k, and gclk_o has no pulse from edge k+1 on. With sw_halt_en_i at 0 the strobe has no effect and gclk_o keeps pulsing.
- R3: When susp_ni is held low, hw_susp_en_i is 1 and SYNC_STAGES is 2, a low level first driven before edge e gives pulses at edges e, e+1 and e+2, and no pulse from edge e+3 on. With hw_susp_en_i at 0 the pin is ignored.
- R4: A halt entered through the pin ignores the soft reset and all interrupts. It ends only when susp_ni goes high, or on rst_ni. A release driven before edge e wakes the clock at edge e+2 and sets wake_src_o to 5 there.
- R5: A halt entered through the strobe ends on soft_rst_i, on mgmt_irq_i, on a qualified NMI, or on a qualified INTR. These inputs are levels sampled while the clock is off.
- R6: susp_ack_no goes low one edge after the gate closes. When a wake is sampled at edge w, gclk_o pulses again from edge w+1 and susp_ack_no returns to 1 at edge w+1.
- R7: wake_src_o is updated at the wake edge and names the highest-priority source present. The codes are 1 for soft reset, 2 for management interrupt, 3 for NMI, 4 for INTR and 5 for pin release, and this is also the priority order.
- R8: INTR wakes a halt only while if_flag_i is 1. Otherwise it is ignored and the clock stays off.
- R9: While in_mgmt_i is 1, a halt strobe is taken only if if_flag_i or nmi_en_i is 1. In that mode an NMI wakes the halt only if nmi_en_i is 1.
- R10: gclk_o is never high while clk_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_halt_en_i | input | 1 | Enable for halt-strobe entry |
| hw_susp_en_i | input | 1 | Enable for suspend-pin entry |
| halt_req_i | input | 1 | One-cycle halt strobe from the core |
| susp_ni | input | 1 | Suspend pin, active low, asynchronous |
| soft_rst_i | input | 1 | Soft reset wake request |
| mgmt_irq_i | input | 1 | Management interrupt wake request |
| in_mgmt_i | input | 1 | Core is in management mode |
| if_flag_i | input | 1 | Interrupt flag; qualifies INTR |
| intr_i | input | 1 | Maskable interrupt request |
| nmi_i | input | 1 | Non-maskable interrupt request |
| nmi_en_i | input | 1 | NMI enabled inside management mode |
| gclk_o | output | 1 | Gated core clock |
| susp_ack_no | output | 1 | Suspend acknowledge, active low |
| wake_src_o | output | 3 | Cause of the last wake |

## Verification
A halt strobe takes effect at the next edge, and the gate removes the pulse one edge later. The acknowledge falls on that same later edge. A pin change needs two synchronizer edges plus one state edge before it acts. A wake moves the cause code at the edge where it is sampled, and the clock pulse and acknowledge return one edge after that. Each stimulus queues the expected gated-clock level, acknowledge and cause for the exact edge index when they are due. The monitor compares them in the middle of the high phase after that edge, and it also checks in every low phase that the gated clock is low.

// File: rtl/lph_pkg.sv
package lph_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_GATE, ST_OFF, ST_WAKE} lph_state_e;

  typedef enum logic [2:0] {
    WK_NONE = 3'd0,
    WK_SRST = 3'd1,
    WK_MGMT = 3'd2,
    WK_NMI  = 3'd3,
    WK_INTR = 3'd4,
    WK_PIN  = 3'd5
  } lph_wake_e;

  localparam int unsigned NUM_SW_WAKE = 4;
endpackage

// File: rtl/lph_sync.sv
module lph_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_chain
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff_q <= {STAGES{RST_VAL}};
      end else begin
        ff_q[0] <= d_i;
        for (int i = 1; i < int'(STAGES); i++) ff_q[i] <= ff_q[i-1];
      end
    end
    assign q_o = ff_q[STAGES-1];
  end
endmodule

// File: rtl/lph_wake_arb.sv
module lph_wake_arb
  import lph_pkg::*;
(
  input  logic      soft_rst_i,
  input  logic      mgmt_irq_i,
  input  logic      nmi_i,
  input  logic      intr_i,
  input  logic      in_mgmt_i,
  input  logic      if_flag_i,
  input  logic      nmi_en_i,
  output logic      any_o,
  output lph_wake_e cause_o
);
  logic nmi_ok, intr_ok;
  logic [NUM_SW_WAKE-1:0] req;

  assign nmi_ok  = nmi_i & (~in_mgmt_i | nmi_en_i);
  assign intr_ok = intr_i & if_flag_i;
  // bit 0 wins
  assign req     = {intr_ok, nmi_ok, mgmt_irq_i, soft_rst_i};
  assign any_o   = |req;

  always_comb begin
    cause_o = WK_NONE;
    for (int i = NUM_SW_WAKE - 1; i >= 0; i--) begin
      if (req[i]) cause_o = lph_wake_e'(3'(i + 1));
    end
  end
endmodule

// File: rtl/lph_fsm.sv
module lph_fsm
  import lph_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sw_entry_i,
  input  logic       hw_entry_i,
  input  logic       pin_rel_i,
  input  logic       wake_any_i,
  input  lph_wake_e  wake_cause_i,
  output lph_state_e st_o,
  output logic       hw_mode_o,
  output logic       clk_en_o,
  output logic       ack_no,
  output logic [2:0] wake_src_o
);
  lph_state_e st_q, st_d;
  logic       hw_q, hw_d;
  logic       en_q, en_d;
  logic       ack_q, ack_d;
  lph_wake_e  src_q, src_d;

  always_comb begin
    st_d  = st_q;
    hw_d  = hw_q;
    en_d  = en_q;
    ack_d = ack_q;
    src_d = src_q;
    unique case (st_q)
      ST_RUN: begin
        if (hw_entry_i) begin
          st_d = ST_GATE;
          hw_d = 1'b1;
          en_d = 1'b0;
        end else if (sw_entry_i) begin
          st_d = ST_GATE;
          hw_d = 1'b0;
          en_d = 1'b0;
        end
      end
      ST_GATE: begin
        st_d  = ST_OFF;
        ack_d = 1'b0;
      end
      ST_OFF: begin
        if (hw_q) begin
          if (pin_rel_i) begin
            st_d  = ST_WAKE;
            en_d  = 1'b1;
            src_d = WK_PIN;
          end
        end else if (wake_any_i) begin
          st_d  = ST_WAKE;
          en_d  = 1'b1;
          src_d = wake_cause_i;
        end
      end
      ST_WAKE: begin
        st_d  = ST_RUN;
        ack_d = 1'b1;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      hw_q  <= 1'b0;
      en_q  <= 1'b1;
      ack_q <= 1'b1;
      src_q <= WK_NONE;
    end else begin
      st_q  <= st_d;
      hw_q  <= hw_d;
      en_q  <= en_d;
      ack_q <= ack_d;
      src_q <= src_d;
    end
  end

  assign st_o       = st_q;
  assign hw_mode_o  = hw_q;
  assign clk_en_o   = en_q;
  assign ack_no     = ack_q;
  assign wake_src_o = src_q;
endmodule

// File: rtl/lph_clk_gate.sv
module lph_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lat;

  // transparent only in low phase
  always_latch begin
    if (!clk_i) en_lat <= en_i;
  end

  assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/lph_clk_ctrl.sv
module lph_clk_ctrl
  import lph_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sw_halt_en_i,
  input  logic       hw_susp_en_i,
  input  logic       halt_req_i,
  input  logic       susp_ni,
  input  logic       soft_rst_i,
  input  logic       mgmt_irq_i,
  input  logic       in_mgmt_i,
  input  logic       if_flag_i,
  input  logic       intr_i,
  input  logic       nmi_i,
  input  logic       nmi_en_i,
  output logic       gclk_o,
  output logic       susp_ack_no,
  output logic [2:0] wake_src_o
);
  logic       pin_sync;
  logic       sw_entry, hw_entry;
  logic       wake_any;
  lph_wake_e  wake_cause;
  lph_state_e st;
  logic       hw_mode;
  logic       clk_en;

  lph_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (susp_ni),
    .q_o   (pin_sync)
  );

  // management mode needs a wake source before a halt is taken
  assign sw_entry = halt_req_i & sw_halt_en_i & (~in_mgmt_i | if_flag_i | nmi_en_i);
  assign hw_entry = ~pin_sync & hw_susp_en_i;

  lph_wake_arb u_arb (
    .soft_rst_i(soft_rst_i),
    .mgmt_irq_i(mgmt_irq_i),
    .nmi_i     (nmi_i),
    .intr_i    (intr_i),
    .in_mgmt_i (in_mgmt_i),
    .if_flag_i (if_flag_i),
    .nmi_en_i  (nmi_en_i),
    .any_o     (wake_any),
    .cause_o   (wake_cause)
  );

  lph_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_entry_i  (sw_entry),
    .hw_entry_i  (hw_entry),
    .pin_rel_i   (pin_sync),
    .wake_any_i  (wake_any),
    .wake_cause_i(wake_cause),
    .st_o        (st),
    .hw_mode_o   (hw_mode),
    .clk_en_o    (clk_en),
    .ack_no      (susp_ack_no),
    .wake_src_o  (wake_src_o)
  );

  lph_clk_gate u_gate (
    .clk_i (clk_i),
    .en_i  (clk_en),
    .gclk_o(gclk_o)
  );
endmodule

// File: rtl/lph_clk_ctrl_chk.sv
module lph_clk_ctrl_chk
  import lph_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       halt_req_i,
  input logic       sw_halt_en_i,
  input logic       hw_susp_en_i,
  input logic       if_flag_i,
  input logic       intr_i,
  input logic       nmi_i,
  input logic       soft_rst_i,
  input logic       mgmt_irq_i,
  input logic       susp_ack_no,
  input logic [2:0] wake_src_o,
  input logic       clk_en,
  input lph_state_e st,
  input logic       hw_mode,
  input logic       pin_sync
);
  // R6
  ack_after_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(susp_ack_no) |-> (!clk_en && $past(!clk_en)));

  // R6
  ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp_ack_no) |-> (clk_en && $past(clk_en)));

  // R4
  hw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_OFF && hw_mode && !pin_sync) |=> !clk_en);

  // R8
  intr_unqualified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_OFF && !hw_mode && intr_i && !if_flag_i && !nmi_i && !soft_rst_i && !mgmt_irq_i)
    |=> !clk_en);

  // R2
  sw_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RUN && halt_req_i && !sw_halt_en_i && !(hw_susp_en_i && !pin_sync)) |=> clk_en);

  // R7
  cause_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en) |-> (wake_src_o != 3'd0));
endmodule

bind lph_clk_ctrl lph_clk_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .halt_req_i  (halt_req_i),
  .sw_halt_en_i(sw_halt_en_i),
  .hw_susp_en_i(hw_susp_en_i),
  .if_flag_i   (if_flag_i),
  .intr_i      (intr_i),
  .nmi_i       (nmi_i),
  .soft_rst_i  (soft_rst_i),
  .mgmt_irq_i  (mgmt_irq_i),
  .susp_ack_no (susp_ack_no),
  .wake_src_o  (wake_src_o),
  .clk_en      (clk_en),
  .st          (st),
  .hw_mode     (hw_mode),
  .pin_sync    (pin_sync)
);

// File: tb/lph_clk_ctrl_bench.sv
module lph_clk_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_en = 1'b0, hw_en = 1'b0, halt_req = 1'b0, susp_n = 1'b1;
  logic soft_rst = 1'b0, mgmt_irq = 1'b0, in_mgmt = 1'b0, if_flag = 1'b0;
  logic intr = 1'b0, nmi = 1'b0, nmi_en = 1'b0;
  logic gclk, ack_n;
  logic [2:0] wsrc;

  always #10 clk = ~clk;

  lph_clk_ctrl u_lph_clk_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sw_halt_en_i(sw_en), .hw_susp_en_i(hw_en),
    .halt_req_i(halt_req), .susp_ni(susp_n), .soft_rst_i(soft_rst),
    .mgmt_irq_i(mgmt_irq), .in_mgmt_i(in_mgmt), .if_flag_i(if_flag),
    .intr_i(intr), .nmi_i(nmi), .nmi_en_i(nmi_en),
    .gclk_o(gclk), .susp_ack_no(ack_n), .wake_src_o(wsrc)
  );

  typedef struct packed {
    int         cyc;
    logic       g;
    logic       a;
    logic [2:0] s;
  } exp_t;

  exp_t  eq[$];
  string tq[$];
  exp_t  cur;
  string cur_tag;
  int    cyc_cnt = 0;
  int    total = 0;
  int    bad = 0;
  logic [2:0] src_exp = 3'd0;
  bit    done = 1'b0;

  task automatic push(input int dly, input logic g, input logic a, input logic [2:0] s,
                      input string r);
    exp_t e;
    e.cyc = cyc_cnt + dly;
    e.g = g;
    e.a = a;
    e.s = s;
    eq.push_back(e);
    tq.push_back(r);
  endtask

  // monitor
  always @(posedge clk) begin
    cyc_cnt++;
    #5;
    while (eq.size() > 0 && eq[0].cyc <= cyc_cnt) begin
      cur = eq.pop_front();
      cur_tag = tq.pop_front();
      total++;
      if (cur.cyc != cyc_cnt || gclk !== cur.g || ack_n !== cur.a || wsrc !== cur.s) begin
        bad++;
        $display("FAIL %s cyc=%0d gclk/ack/src act=%b/%b/%0d exp=%b/%b/%0d",
                 cur_tag, cur.cyc, gclk, ack_n, wsrc, cur.g, cur.a, cur.s);
      end
    end
    #10;
    total++;
    if (gclk !== 1'b0) begin
      bad++;
      $display("FAIL R10 low phase gclk act=%b exp=0", gclk);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_run(input int n, input string r);
    repeat (n) begin
      push(1, 1'b1, 1'b1, src_exp, r);
      @(negedge clk);
    end
  endtask

  task automatic hold_off(input int n, input string r);
    repeat (n) begin
      push(1, 1'b0, 1'b0, src_exp, r);
      @(negedge clk);
    end
  endtask

  // enter halt by strobe; returns with clock off
  task automatic sw_halt();
    halt_req = 1'b1;
    push(1, 1'b1, 1'b1, src_exp, "R2");
    push(2, 1'b0, 1'b0, src_exp, "R6");
    @(negedge clk);
    halt_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic wake_by(input logic sr, input logic mi, input logic nm, input logic it,
                         input logic [2:0] s, input string r);
    soft_rst = sr; mgmt_irq = mi; nmi = nm; intr = it;
    push(1, 1'b0, 1'b0, s, r);
    push(2, 1'b1, 1'b1, s, "R6");
    @(negedge clk);
    soft_rst = 1'b0; mgmt_irq = 1'b0; nmi = 1'b0; intr = 1'b0;
    src_exp = s;
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    tick(2);
    // R1 during reset
    total++;
    if (ack_n !== 1'b1 || wsrc !== 3'd0) begin
      bad++;
      $display("FAIL R1 reset act=%b/%0d exp=1/0", ack_n, wsrc);
    end
    push(1, 1'b1, 1'b1, 3'd0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    expect_run(2, "R1");

    // R8 unqualified INTR, then NMI wake (R5)
    sw_en = 1'b1;
    sw_halt();
    intr = 1'b1;
    hold_off(3, "R8");
    intr = 1'b0;
    wake_by(0, 0, 1, 0, 3'd3, "R5");

    // R8 qualified INTR
    sw_halt();
    if_flag = 1'b1;
    wake_by(0, 0, 0, 1, 3'd4, "R8");
    if_flag = 1'b0;

    // R5 soft reset and management interrupt
    sw_halt();
    wake_by(1, 0, 0, 0, 3'd1, "R5");
    sw_halt();
    wake_by(0, 1, 0, 0, 3'd2, "R5");

    // R7 priority
    if_flag = 1'b1;
    sw_halt();
    wake_by(1, 1, 1, 1, 3'd1, "R7");
    sw_halt();
    wake_by(0, 1, 1, 1, 3'd2, "R7");
    sw_halt();
    wake_by(0, 0, 1, 1, 3'd3, "R7");
    if_flag = 1'b0;

    // R2 disabled strobe
    sw_en = 1'b0;
    halt_req = 1'b1;
    expect_run(1, "R2");
    halt_req = 1'b0;
    expect_run(3, "R2");
    sw_en = 1'b1;

    // R9 management mode qualification
    in_mgmt = 1'b1;
    halt_req = 1'b1;
    expect_run(1, "R9");
    halt_req = 1'b0;
    expect_run(3, "R9");
    if_flag = 1'b1;
    sw_halt();
    nmi = 1'b1;
    hold_off(3, "R9");
    nmi = 1'b0;
    wake_by(0, 0, 0, 1, 3'd4, "R9");
    if_flag = 1'b0;
    nmi_en = 1'b1;
    sw_halt();
    wake_by(0, 0, 1, 0, 3'd3, "R9");
    in_mgmt = 1'b0;
    nmi_en = 1'b0;

    // R3 pin ignored while disabled
    susp_n = 1'b0;
    expect_run(5, "R3");
    susp_n = 1'b1;
    expect_run(3, "R3");

    // R3 pin entry
    hw_en = 1'b1;
    susp_n = 1'b0;
    push(1, 1'b1, 1'b1, src_exp, "R3");
    push(2, 1'b1, 1'b1, src_exp, "R3");
    push(3, 1'b1, 1'b1, src_exp, "R3");
    push(4, 1'b0, 1'b0, src_exp, "R3");
    tick(4);
    // R4 other wakes ignored
    soft_rst = 1'b1; mgmt_irq = 1'b1; nmi = 1'b1; intr = 1'b1; if_flag = 1'b1;
    hold_off(4, "R4");
    soft_rst = 1'b0; mgmt_irq = 1'b0; nmi = 1'b0; intr = 1'b0; if_flag = 1'b0;
    hold_off(1, "R4");
    // R4 release
    susp_n = 1'b1;
    push(1, 1'b0, 1'b0, src_exp, "R4");
    push(2, 1'b0, 1'b0, src_exp, "R4");
    push(3, 1'b0, 1'b0, 3'd5, "R4");
    push(4, 1'b1, 1'b1, 3'd5, "R6");
    tick(4);
    src_exp = 3'd5;
    hw_en = 1'b0;
    expect_run(2, "R4");

    // R1 reset while halted
    sw_halt();
    rst_n = 1'b0;
    #1;
    total++;
    if (ack_n !== 1'b1 || wsrc !== 3'd0) begin
      bad++;
      $display("FAIL R1 async reset act=%b/%0d exp=1/0", ack_n, wsrc);
    end
    src_exp = 3'd0;
    push(1, 1'b1, 1'b1, 3'd0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    expect_run(3, "R1");

    tick(3);
    finish_up();
  end
endmodule